// File: doc/BRIEF.md
# Instruction Length and Cycle Estimator

This block takes the first 16-bit word of an instruction for a 16-bit two-address processor. It returns four things: which encoding family the word belongs to, how many words the whole instruction takes (1 to 3), how many clock cycles it needs, and whether the word is an encoding the block does not support. A fetch sequencer uses the length to know how many extension words follow. A cycle-accurate model uses the cycle count to advance time without walking the operand accesses.

The decode itself is purely combinational. The results can be captured in a register stage with a clock enable (the default, `OUT_REG = 1`, one cycle of latency), or passed straight through. Cost is built from one rule per memory access. The fetch is one cycle. An indexed operand costs two more cycles and one extension word. An indirect or immediate source costs one cycle, and an immediate also costs a word. A result stored to memory costs one cycle, and a result written to the program counter costs one more. Constant sources drawn from registers 2 and 3 cost nothing.

Top module: `isa_len_calc`

## Requirements
- R1: The opcode nibble instr[15:12] selects the family, reported on `out_fmt`: 0100 through 1111 give two-operand (code 0), 0001 gives one-operand (code 1), 0010 and 0011 give jump (code 2), and anything unsupported gives code 3.
- R2: A two-operand word has source register in [11:8], destination mode in [7], byte flag in [6], source mode in [5:4] and destination register in [3:0]. Its length is 1 word, plus 1 for an indexed source (mode 01), plus 1 for an immediate source (mode 11 with register 0), plus 1 when the destination mode is 1.
- R3: Constant sources add neither a word nor a cycle. These are register 3 in modes 01, 10 or 11, and register 2 in modes 10 or 11. Register 2 in mode 01 is an absolute address and costs the same as any indexed source.
- R4: The cycle count starts at 1 for the fetch. Source mode 01 adds 2, and modes 10 and 11 add 1, unless the source is a constant.
- R5: An indexed destination adds 2 cycles, plus 1 for storing the result. Compare (1001) and bit-test (1011) store nothing, so they never pay the store cycle.
- R6: A register-mode result written to register 0 adds 1 cycle. Compare and bit-test are exempt because they do not write.
- R7: Jumps report 1 word and 2 cycles, whatever their condition and offset.
- R8: A one-operand word has operation code in [9:7], byte flag in [6], mode in [5:4] and register in [3:0]. Operations are 000 rotate through carry, 001 byte swap, 010 arithmetic shift right, 011 sign extend, 100 push and 101 call. Source word and cycle rules follow R2 to R4. The shift, swap and extend operations add 1 cycle when the operand is in memory, or 1 when in register mode on register 0. Push adds 1 cycle for its stack write. Call adds 1 for its stack write and 1 for its program-counter write.
- R9: The following words set `out_illegal`, report `out_fmt` 3, and report 1 word and 1 cycle: opcode 0000; a one-operand word with [11:10] not 00; operation 110 or 111; and byte swap, sign extend or call with the byte flag set.
- R10: With the register stage, results appear one clock after `in_valid`, and `out_valid` is high for exactly that cycle. When `in_valid` is low, every result output holds its last value.
- R11: While reset is asserted, and after it until the first valid word, `out_valid`, `out_fmt`, `out_len`, `out_cycles` and `out_illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `instr`, enables capture |
| instr | input | 16 | First word of the instruction |
| out_valid | output | 1 | Results belong to a captured word |
| out_fmt | output | 2 | Family code per R1 |
| out_len | output | 2 | Instruction length in words |
| out_cycles | output | 4 | Execution cycle count |
| out_illegal | output | 1 | Unsupported encoding |

## Verification
Several cost terms can land on the same word at once. A memory-to-memory move with a PC-relative source pays an indexed source, an indexed destination and the store together. A register-mode write to register 0 stacks the PC-write cycle on top of an indirect or immediate source cost. The vector table holds words that combine two or three of these terms, plus their compare and bit-test twins, where the store and PC-write terms must vanish. Each word is judged against a hand-summed length and cycle count. A separate back-to-back sequence followed by idle cycles checks that the capture enable and the hold behaviour do not interfere.

// File: rtl/isa_len_pkg.sv
package isa_len_pkg;

  localparam int unsigned OPC_MSB = 15;
  localparam int unsigned OPC_LSB = 12;
  localparam int unsigned RN_W    = 4;

  localparam logic [3:0] OPC_SINGLE = 4'b0001;
  localparam logic [3:0] OPC_CMP    = 4'b1001;
  localparam logic [3:0] OPC_BIT    = 4'b1011;
  localparam logic [3:0] OPC_FIRST2 = 4'b0100;

  localparam logic [RN_W-1:0] REG_PC  = 4'd0;
  localparam logic [RN_W-1:0] REG_SR  = 4'd2;
  localparam logic [RN_W-1:0] REG_CG2 = 4'd3;

  typedef enum logic [1:0] {
    FMT_DOUBLE  = 2'd0,
    FMT_SINGLE  = 2'd1,
    FMT_JUMP    = 2'd2,
    FMT_ILLEGAL = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    SOP_RRC  = 3'd0,
    SOP_SWPB = 3'd1,
    SOP_RRA  = 3'd2,
    SOP_SXT  = 3'd3,
    SOP_PUSH = 3'd4,
    SOP_CALL = 3'd5,
    SOP_RSV6 = 3'd6,
    SOP_RSV7 = 3'd7
  } sop_e;

  typedef enum logic [1:0] {
    AM_REG  = 2'b00,
    AM_IDX  = 2'b01,
    AM_IND  = 2'b10,
    AM_INCR = 2'b11
  } amode_e;

endpackage

// File: rtl/isa_fmt_decode.sv
module isa_fmt_decode
  import isa_len_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] instr,
  output fmt_e              fmt,
  output sop_e              sop,
  output logic              writes_dst
);

  logic [3:0] opc;
  logic [1:0] sel_pad;
  logic       byte_flag;
  logic       single_ok;
  logic [WORD_W-1:0] unused_bits;

  assign opc       = instr[OPC_MSB:OPC_LSB];
  assign sel_pad   = instr[11:10];
  assign byte_flag = instr[6];
  assign sop       = sop_e'(instr[9:7]);
  assign unused_bits = instr;

  // Legality of one-operand words: reserved pad, reserved ops, byte forms
  // that only exist as words.
  always_comb begin
    single_ok = (sel_pad == 2'b00);
    unique case (sop)
      SOP_RRC, SOP_RRA, SOP_PUSH: ;
      SOP_SWPB, SOP_SXT, SOP_CALL: if (byte_flag) single_ok = 1'b0;
      default: single_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (opc >= OPC_FIRST2)            fmt = FMT_DOUBLE;
    else if (opc[3:1] == 3'b001)      fmt = FMT_JUMP;
    else if (opc == OPC_SINGLE)       fmt = single_ok ? FMT_SINGLE : FMT_ILLEGAL;
    else                              fmt = FMT_ILLEGAL;
  end

  assign writes_dst = (opc != OPC_CMP) && (opc != OPC_BIT);

endmodule

// File: rtl/isa_src_cost.sv
module isa_src_cost
  import isa_len_pkg::*;
#(
  parameter int unsigned CYC_W = 4
) (
  input  amode_e             amode,
  input  logic [RN_W-1:0]    rnum,
  output logic               ext_word,
  output logic [CYC_W-1:0]   src_cyc,
  output logic               is_mem,
  output logic               is_const
);

  logic is_imm;

  assign is_const = ((rnum == REG_CG2) && (amode != AM_REG)) ||
                    ((rnum == REG_SR)  && amode[1]);
  assign is_imm   = (amode == AM_INCR) && (rnum == REG_PC);

  always_comb begin
    ext_word = 1'b0;
    src_cyc  = '0;
    if (!is_const) begin
      unique case (amode)
        AM_REG:  src_cyc = '0;
        AM_IDX:  begin src_cyc = CYC_W'(2); ext_word = 1'b1; end
        AM_IND:  src_cyc = CYC_W'(1);
        AM_INCR: begin src_cyc = CYC_W'(1); ext_word = is_imm; end
      endcase
    end
  end

  assign is_mem = (amode != AM_REG) && !is_const && !is_imm;

endmodule

// File: rtl/isa_cost_sum.sv
module isa_cost_sum
  import isa_len_pkg::*;
#(
  parameter int unsigned LEN_W = 2,
  parameter int unsigned CYC_W = 4
) (
  input  fmt_e              fmt,
  input  sop_e              sop,
  input  logic              writes_dst,
  input  logic              dst_idx,
  input  logic [RN_W-1:0]   dst_reg,
  input  amode_e            amode,
  input  logic              src_ext,
  input  logic [CYC_W-1:0]  src_cyc,
  input  logic              src_mem,
  output logic [LEN_W-1:0]  len,
  output logic [CYC_W-1:0]  cyc
);

  localparam logic [CYC_W-1:0] CYC_ONE = CYC_W'(1);
  localparam logic [CYC_W-1:0] CYC_TWO = CYC_W'(2);

  logic shift_like;
  logic pc_reg_wr;

  assign shift_like = (sop == SOP_RRC) || (sop == SOP_SWPB) ||
                      (sop == SOP_RRA) || (sop == SOP_SXT);
  assign pc_reg_wr  = (dst_reg == REG_PC);

  always_comb begin
    len = LEN_W'(1);
    cyc = CYC_ONE;
    unique case (fmt)
      FMT_DOUBLE: begin
        len = LEN_W'(1) + LEN_W'(src_ext) + LEN_W'(dst_idx);
        cyc = CYC_ONE + src_cyc;
        if (dst_idx) begin
          cyc = cyc + CYC_TWO;
          if (writes_dst) cyc = cyc + CYC_ONE;
        end else if (writes_dst && pc_reg_wr) begin
          cyc = cyc + CYC_ONE;
        end
      end
      FMT_SINGLE: begin
        len = LEN_W'(1) + LEN_W'(src_ext);
        cyc = CYC_ONE + src_cyc;
        if (shift_like && src_mem) cyc = cyc + CYC_ONE;
        if (shift_like && (amode == AM_REG) && pc_reg_wr) cyc = cyc + CYC_ONE;
        if (sop == SOP_PUSH) cyc = cyc + CYC_ONE;
        if (sop == SOP_CALL) cyc = cyc + CYC_TWO;
      end
      FMT_JUMP: begin
        len = LEN_W'(1);
        cyc = CYC_TWO;
      end
      default: begin
        len = LEN_W'(1);
        cyc = CYC_ONE;
      end
    endcase
  end

endmodule

// File: rtl/isa_len_calc.sv
module isa_len_calc
  import isa_len_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned LEN_W   = 2,
  parameter int unsigned CYC_W   = 4,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] instr,
  output logic              out_valid,
  output logic [1:0]        out_fmt,
  output logic [LEN_W-1:0]  out_len,
  output logic [CYC_W-1:0]  out_cycles,
  output logic              out_illegal
);

  fmt_e             fmt_c;
  sop_e             sop_c;
  logic             writes_c;
  amode_e           amode_c;
  logic [RN_W-1:0]  src_reg_c;
  logic             src_ext_c;
  logic [CYC_W-1:0] src_cyc_c;
  logic             src_mem_c;
  logic             src_const_c;
  logic [LEN_W-1:0] len_c;
  logic [CYC_W-1:0] cyc_c;

  assign amode_c   = amode_e'(instr[5:4]);
  assign src_reg_c = (fmt_c == FMT_DOUBLE) ? instr[11:8] : instr[3:0];

  isa_fmt_decode #(.WORD_W(WORD_W)) u_decode (
    .instr      (instr),
    .fmt        (fmt_c),
    .sop        (sop_c),
    .writes_dst (writes_c)
  );

  isa_src_cost #(.CYC_W(CYC_W)) u_src (
    .amode    (amode_c),
    .rnum     (src_reg_c),
    .ext_word (src_ext_c),
    .src_cyc  (src_cyc_c),
    .is_mem   (src_mem_c),
    .is_const (src_const_c)
  );

  isa_cost_sum #(.LEN_W(LEN_W), .CYC_W(CYC_W)) u_sum (
    .fmt        (fmt_c),
    .sop        (sop_c),
    .writes_dst (writes_c),
    .dst_idx    (instr[7] && (fmt_c == FMT_DOUBLE)),
    .dst_reg    (instr[3:0]),
    .amode      (amode_c),
    .src_ext    (src_ext_c),
    .src_cyc    (src_cyc_c),
    .src_mem    (src_mem_c),
    .len        (len_c),
    .cyc        (cyc_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic             vld_q, vld_d;
      logic [1:0]       fmt_q, fmt_d;
      logic [LEN_W-1:0] len_q, len_d;
      logic [CYC_W-1:0] cyc_q, cyc_d;
      logic             ill_q, ill_d;
      logic             cap_en;

      assign cap_en = in_valid;

      always_comb begin
        vld_d = in_valid;
        fmt_d = fmt_q;
        len_d = len_q;
        cyc_d = cyc_q;
        ill_d = ill_q;
        if (cap_en) begin
          fmt_d = fmt_c;
          len_d = len_c;
          cyc_d = cyc_c;
          ill_d = (fmt_c == FMT_ILLEGAL);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          fmt_q <= '0;
          len_q <= '0;
          cyc_q <= '0;
          ill_q <= 1'b0;
        end else begin
          vld_q <= vld_d;
          fmt_q <= fmt_d;
          len_q <= len_d;
          cyc_q <= cyc_d;
          ill_q <= ill_d;
        end
      end

      assign out_valid   = vld_q;
      assign out_fmt     = fmt_q;
      assign out_len     = len_q;
      assign out_cycles  = cyc_q;
      assign out_illegal = ill_q;

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
      AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_len) && $stable(out_cycles) && $stable(out_fmt))); // R10
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk  = clk ^ rst_n;
      assign out_valid   = in_valid;
      assign out_fmt     = fmt_c;
      assign out_len     = len_c;
      assign out_cycles  = cyc_c;
      assign out_illegal = (fmt_c == FMT_ILLEGAL);
    end
  endgenerate

  logic unused_const;
  assign unused_const = src_const_c;

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0)); // R2
  AST_CYC_COVERS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_cycles >= CYC_W'(out_len))); // R4
  AST_JUMP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == FMT_JUMP) |-> (out_cycles == CYC_W'(2) && out_len == LEN_W'(1))); // R7
  AST_ILLEGAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_fmt == FMT_ILLEGAL && out_len == LEN_W'(1) && out_cycles == CYC_W'(1))); // R9

endmodule

// File: tb/tb_isa_len_calc.sv
module tb_isa_len_calc;

  localparam int NV = 44;
  // packed: instr[24:9] len[8:7] cyc[6:3] fmt[2:1] ill[0]
  localparam logic [24:0] VEC [NV] = '{
    {16'h540A, 2'd1, 4'd1, 2'd0, 1'b0}, // R2 R4 register to register
    {16'h541A, 2'd2, 4'd3, 2'd0, 1'b0}, // R2 R4 indexed source
    {16'h542A, 2'd1, 4'd2, 2'd0, 1'b0}, // R4 indirect
    {16'h543A, 2'd1, 4'd2, 2'd0, 1'b0}, // R4 auto-increment
    {16'h501A, 2'd2, 4'd3, 2'd0, 1'b0}, // R2 PC-relative source
    {16'h521A, 2'd2, 4'd3, 2'd0, 1'b0}, // R3 absolute, not a constant
    {16'h503A, 2'd2, 4'd2, 2'd0, 1'b0}, // R2 immediate
    {16'h531A, 2'd1, 4'd1, 2'd0, 1'b0}, // R3 constant 1
    {16'h522A, 2'd1, 4'd1, 2'd0, 1'b0}, // R3 constant 4
    {16'h523A, 2'd1, 4'd1, 2'd0, 1'b0}, // R3 constant 8
    {16'h533A, 2'd1, 4'd1, 2'd0, 1'b0}, // R3 constant -1
    {16'h532A, 2'd1, 4'd1, 2'd0, 1'b0}, // R3 constant 2
    {16'h5090, 2'd3, 4'd6, 2'd0, 1'b0}, // R2 R5 memory to memory
    {16'h4485, 2'd2, 4'd4, 2'd0, 1'b0}, // R5 register to indexed
    {16'h45A6, 2'd2, 4'd5, 2'd0, 1'b0}, // R5 indirect to indexed
    {16'h4596, 2'd3, 4'd6, 2'd0, 1'b0}, // R5 indexed to indexed
    {16'h40B2, 2'd3, 4'd5, 2'd0, 1'b0}, // R2 R5 immediate to absolute
    {16'h427F, 2'd1, 4'd1, 2'd0, 1'b0}, // R3 byte constant 8
    {16'h9495, 2'd3, 4'd5, 2'd0, 1'b0}, // R5 compare, no store
    {16'hB425, 2'd1, 4'd2, 2'd0, 1'b0}, // R5 bit test
    {16'h9400, 2'd1, 4'd1, 2'd0, 1'b0}, // R6 compare to PC exempt
    {16'h4400, 2'd1, 4'd2, 2'd0, 1'b0}, // R6 move to PC
    {16'h4530, 2'd1, 4'd3, 2'd0, 1'b0}, // R6 pop to PC
    {16'hE030, 2'd2, 4'd3, 2'd0, 1'b0}, // R6 immediate xor to PC
    {16'hB495, 2'd3, 4'd5, 2'd0, 1'b0}, // R5 bit test indexed both
    {16'h5FFF, 2'd2, 4'd5, 2'd0, 1'b0}, // R2 byte @r15+ to indexed
    {16'h2FE4, 2'd1, 4'd2, 2'd2, 1'b0}, // R7 R1 jump on carry
    {16'h3FFC, 2'd1, 4'd2, 2'd2, 1'b0}, // R7 unconditional
    {16'h1005, 2'd1, 4'd1, 2'd1, 1'b0}, // R8 R1 rotate register
    {16'h1000, 2'd1, 4'd2, 2'd1, 1'b0}, // R8 rotate PC
    {16'h1115, 2'd2, 4'd4, 2'd1, 1'b0}, // R8 shift indexed
    {16'h10A5, 2'd1, 4'd3, 2'd1, 1'b0}, // R8 swap indirect
    {16'h1186, 2'd1, 4'd1, 2'd1, 1'b0}, // R8 sign extend
    {16'h1205, 2'd1, 4'd2, 2'd1, 1'b0}, // R8 push register
    {16'h1230, 2'd2, 4'd3, 2'd1, 1'b0}, // R8 push immediate
    {16'h1213, 2'd1, 4'd2, 2'd1, 1'b0}, // R8 R3 push constant
    {16'h1285, 2'd1, 4'd3, 2'd1, 1'b0}, // R8 call register
    {16'h12B0, 2'd2, 4'd4, 2'd1, 1'b0}, // R8 call immediate
    {16'h1295, 2'd2, 4'd5, 2'd1, 1'b0}, // R8 call indexed
    {16'h1030, 2'd2, 4'd2, 2'd1, 1'b0}, // R8 rotate immediate
    {16'h1300, 2'd1, 4'd1, 2'd3, 1'b1}, // R9 reserved op 110
    {16'h0ABC, 2'd1, 4'd1, 2'd3, 1'b1}, // R9 opcode 0000
    {16'h1405, 2'd1, 4'd1, 2'd3, 1'b1}, // R9 pad bits set
    {16'h12C5, 2'd1, 4'd1, 2'd3, 1'b1}  // R9 byte-flag call
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] instr;
  logic        out_valid;
  logic [1:0]  out_fmt;
  logic [1:0]  out_len;
  logic [3:0]  out_cycles;
  logic        out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  isa_len_calc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .out_valid(out_valid), .out_fmt(out_fmt), .out_len(out_len),
    .out_cycles(out_cycles), .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_vec(input logic [24:0] v);
    chk("R10/valid", int'(out_valid), 1);
    chk("R2/len",    int'(out_len),    int'(v[8:7]));
    chk("R4/cycles", int'(out_cycles), int'(v[6:3]));
    chk("R1/fmt",    int'(out_fmt),    int'(v[2:1]));
    chk("R9/illegal",int'(out_illegal),int'(v[0]));
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = 16'h540A;
    repeat (3) @(negedge clk);
    // R11 reset state, with a word waiting that must not be captured
    chk("R11/valid", int'(out_valid), 0);
    chk("R11/len",   int'(out_len), 0);
    chk("R11/cycles",int'(out_cycles), 0);
    chk("R11/fmt",   int'(out_fmt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11/idle_len", int'(out_len), 0);

    // table walk: one word per cycle, back to back
    for (int i = 0; i < NV; i++) begin
      instr = VEC[i][24:9]; in_valid = 1'b1;
      @(negedge clk);
      check_vec(VEC[i]);
    end

    // R10 hold: idle cycles with a different word present
    in_valid = 1'b0; instr = 16'h5090;
    @(negedge clk);
    chk("R10/valid_low", int'(out_valid), 0);
    chk("R10/hold_len",  int'(out_len), 1);
    chk("R10/hold_ill",  int'(out_illegal), 1);
    @(negedge clk);
    chk("R10/hold_cyc",  int'(out_cycles), 1);

    // R10 single-cycle pulse after a lone word
    in_valid = 1'b1; instr = 16'h5090;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5/len_mm", int'(out_len), 3);
    chk("R5/cyc_mm", int'(out_cycles), 6);
    @(negedge clk);
    chk("R10/pulse_end", int'(out_valid), 0);
    chk("R10/hold_mm",   int'(out_cycles), 6);

    // R11 reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11/rst_cyc", int'(out_cycles), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule